// File: doc/BRIEF.md
# Clock Timing Mode Controller

This block is the mode state machine of a digital clock-recovery loop. It runs with no software involved. Per-reference validity flags drive it, together with a flag that says the selected reference has failed. It chooses one of three modes: free-run, locked and holdover. It also chooses which frequency word the synthesizer gets.

In free-run the output word is a fixed nominal value plus a calibration offset. While locked, the block passes the loop's frequency word through and keeps an exponential average of it. When the selected reference fails, that average becomes the holdover word. From holdover the block asks to move to another valid reference and goes back to locked, and the output word does not change on that step. The phase detector, loop filter and synthesizer are outside this block; a frequency-word input and output stand in for them.

Top module: `clk_mode_ctrl`

## Requirements
- R1: During and right after synchronous reset: `mode_o` is 2'b00, `freq_o` equals NOMINAL, `sel_ref_o` is 0 and `switch_req_o` is 0.
- R2: `mode_o` uses 2'b00 for free-run, 2'b01 for locked and 2'b10 for holdover. It never shows 2'b11.
- R3: In free-run with no valid reference, each clock edge loads `freq_o` with NOMINAL + `cal_offset`, taken modulo 2^FW.
- R4: In free-run, an edge that sees any `ref_valid` bit set moves to locked. It loads `sel_ref_o` with the lowest set index and raises `switch_req_o` for exactly that one cycle.
- R5: In locked with `sel_fail` low, each edge loads `freq_o` with `loop_freq` and updates the stored average as avg + ((loop_freq − avg) >>> AVG_SHIFT), using signed difference and arithmetic shift. The average starts at NOMINAL after reset.
- R6: In locked, `sel_fail` with at least 2^AVG_SHIFT samples averaged moves to holdover, and `freq_o` takes the stored average. That failing sample is not averaged.
- R7: In locked, `sel_fail` with fewer than 2^AVG_SHIFT samples moves to free-run, with `freq_o` = NOMINAL + `cal_offset`. The sample count clears, so the next lock must average 2^AVG_SHIFT samples again.
- R8: In holdover, if any valid reference other than `sel_ref_o` exists, the next edge selects the lowest such index, pulses `switch_req_o` and enters locked. `freq_o` keeps the stored average on that edge.
- R9: In holdover with no other valid reference, the mode stays holdover and `freq_o` stays at the stored average. `sel_fail` has no effect there.
- R10: `switch_req_o` is high only in the first cycle of locked mode after a transition into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | NREF | Per-reference validity flags |
| sel_fail | input | 1 | Selected reference has failed |
| loop_freq | input | FW | Frequency word from the loop filter |
| cal_offset | input | FW | Calibration offset added in free-run (two's complement) |
| mode_o | output | 2 | Current mode |
| freq_o | output | FW | Frequency word for the synthesizer |
| sel_ref_o | output | clog2(NREF) | Index of the selected reference |
| switch_req_o | output | 1 | One-cycle request to switch to `sel_ref_o` |

## Verification
The bench goes after a failure that arrives one sample before the average becomes usable. A design with an off-by-one count would enter holdover with a half-trained word, or would fall back to free-run after a full training. It also checks that the failing sample is kept out of the average; a design that folded it in would hold a word that is one step off. In holdover it sets only the failed reference's flag, so a design that did not exclude the current index would loop back to a dead reference. It also checks that the output word holds across the re-lock edge, because a glitch to the loop word there would break hitless switching. Long pseudo-random runs then compare every output against a model built from the requirements.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_LOCK = 2'b01,
    MODE_HOLD = 2'b10
  } mode_t;
endpackage

// File: rtl/ref_pick.sv
// Lowest-index picker over a candidate mask.
module ref_pick #(
  parameter int NREF = 4,
  localparam int IW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic [NREF-1:0] cand,
  output logic            found,
  output logic [IW-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NREF - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/hold_avg.sv
// Exponential average of the loop word plus a saturating sample counter.
module hold_avg #(
  parameter int FW        = 24,
  parameter int AVG_SHIFT = 6,
  parameter int NOMINAL   = 24'h800000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic          clr_cnt,
  input  logic [FW-1:0] sample,
  output logic [FW-1:0] avg,
  output logic          ready
);
  localparam int CW = AVG_SHIFT + 1;
  localparam logic [FW-1:0] NOM_W = FW'(NOMINAL);

  logic [CW-1:0]        cnt_q;
  logic signed [FW:0]   diff;
  logic signed [FW:0]   step;
  logic [FW-1:0]        avg_nx;

  always_comb begin
    diff   = $signed({1'b0, sample}) - $signed({1'b0, avg});
    step   = diff >>> AVG_SHIFT;
    avg_nx = avg + step[FW-1:0];
  end

  assign ready = cnt_q[AVG_SHIFT];

  always_ff @(posedge clk) begin
    if (rst) begin
      avg   <= NOM_W;
      cnt_q <= '0;
    end else if (clr_cnt) begin
      cnt_q <= '0;
    end else if (upd_en) begin
      avg <= avg_nx;
      if (!cnt_q[AVG_SHIFT]) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mode_fsm.sv
// Free-run / locked / holdover sequencing and reference choice.
module mode_fsm
  import cmc_pkg::*;
#(
  parameter int NREF = 4,
  localparam int IW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREF-1:0] ref_valid,
  input  logic            sel_fail,
  input  logic            hold_ready,
  output mode_t           mode,
  output logic [IW-1:0]   sel,
  output logic            switch_req,
  output logic            upd_en,
  output logic            clr_cnt
);
  logic [NREF-1:0] other_mask;
  logic            any_found, oth_found;
  logic [IW-1:0]   any_idx, oth_idx;

  always_comb begin
    for (int i = 0; i < NREF; i++) other_mask[i] = ref_valid[i] && (IW'(i) != sel);
  end

  ref_pick #(.NREF(NREF)) u_pick_any (.cand(ref_valid),  .found(any_found), .idx(any_idx));
  ref_pick #(.NREF(NREF)) u_pick_oth (.cand(other_mask), .found(oth_found), .idx(oth_idx));

  assign upd_en  = (mode == MODE_LOCK) && !sel_fail;
  assign clr_cnt = (mode == MODE_LOCK) && sel_fail && !hold_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= MODE_FREE;
      sel        <= '0;
      switch_req <= 1'b0;
    end else begin
      switch_req <= 1'b0;
      unique case (mode)
        MODE_FREE: if (any_found) begin
          mode       <= MODE_LOCK;
          sel        <= any_idx;
          switch_req <= 1'b1;
        end
        MODE_LOCK: if (sel_fail) begin
          mode <= hold_ready ? MODE_HOLD : MODE_FREE;
        end
        MODE_HOLD: if (oth_found) begin
          mode       <= MODE_LOCK;
          sel        <= oth_idx;
          switch_req <= 1'b1;
        end
        default: mode <= MODE_FREE;
      endcase
    end
  end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int NREF      = 4,
  parameter int FW        = 24,
  parameter int AVG_SHIFT = 6,
  parameter int NOMINAL   = 24'h800000,
  localparam int IW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREF-1:0] ref_valid,
  input  logic            sel_fail,
  input  logic [FW-1:0]   loop_freq,
  input  logic [FW-1:0]   cal_offset,
  output logic [1:0]      mode_o,
  output logic [FW-1:0]   freq_o,
  output logic [IW-1:0]   sel_ref_o,
  output logic            switch_req_o
);
  localparam logic [FW-1:0] NOM_W = FW'(NOMINAL);

  mode_t         mode;
  logic          upd_en, clr_cnt, ready;
  logic [FW-1:0] avg;
  logic [FW-1:0] free_word;

  assign free_word = NOM_W + cal_offset;

  mode_fsm #(.NREF(NREF)) u_fsm (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .sel_fail(sel_fail),
    .hold_ready(ready), .mode(mode), .sel(sel_ref_o), .switch_req(switch_req_o),
    .upd_en(upd_en), .clr_cnt(clr_cnt)
  );

  hold_avg #(.FW(FW), .AVG_SHIFT(AVG_SHIFT), .NOMINAL(NOMINAL)) u_avg (
    .clk(clk), .rst(rst), .upd_en(upd_en), .clr_cnt(clr_cnt),
    .sample(loop_freq), .avg(avg), .ready(ready)
  );

  assign mode_o = mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_o <= NOM_W;
    end else begin
      unique case (mode)
        MODE_FREE: freq_o <= free_word;
        MODE_LOCK: freq_o <= !sel_fail ? loop_freq : (ready ? avg : free_word);
        MODE_HOLD: freq_o <= avg;
        default:   freq_o <= free_word;
      endcase
    end
  end
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker #(
  parameter int NREF    = 4,
  parameter int FW      = 24,
  parameter int NOMINAL = 24'h800000
) (
  input logic            clk,
  input logic            rst,
  input logic [NREF-1:0] ref_valid,
  input logic            sel_fail,
  input logic [FW-1:0]   cal_offset,
  input logic [1:0]      mode_o,
  input logic [FW-1:0]   freq_o,
  input logic            switch_req_o
);
  localparam logic [FW-1:0] NOM_W = FW'(NOMINAL);

  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst) mode_o != 2'b11);

  // R10
  req_in_lock_chk: assert property (@(posedge clk) disable iff (rst)
    switch_req_o |-> (mode_o == 2'b01));

  // R4
  free_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00 && |ref_valid) |=> (mode_o == 2'b01 && switch_req_o));

  // R3
  free_word_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00 && ref_valid == '0) |=> (freq_o == NOM_W + $past(cal_offset)));

  // R6
  lock_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b01 && sel_fail) |=> (mode_o != 2'b01));

  // R9
  hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b10) |=> $stable(freq_o));
endmodule

bind clk_mode_ctrl cmc_checker #(.NREF(NREF), .FW(FW), .NOMINAL(NOMINAL)) u_cmc_chk (
  .clk(clk), .rst(rst), .ref_valid(ref_valid), .sel_fail(sel_fail),
  .cal_offset(cal_offset), .mode_o(mode_o), .freq_o(freq_o),
  .switch_req_o(switch_req_o)
);

// File: tb/tb_clk_mode_ctrl.sv
module tb_clk_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NREF = 4;
  localparam int FW = 16;
  localparam int K = 2;
  localparam int NOM = 16'h8000;
  localparam int IW = 2;
  localparam int FULL = 1 << K;

  logic clk = 1'b0;
  logic rst;
  logic [NREF-1:0] ref_valid;
  logic sel_fail;
  logic [FW-1:0] loop_freq, cal_offset;
  logic [1:0] mode_o;
  logic [FW-1:0] freq_o;
  logic [IW-1:0] sel_ref_o;
  logic switch_req_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_mode_ctrl #(.NREF(NREF), .FW(FW), .AVG_SHIFT(K), .NOMINAL(NOM)) dut (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .sel_fail(sel_fail),
    .loop_freq(loop_freq), .cal_offset(cal_offset), .mode_o(mode_o),
    .freq_o(freq_o), .sel_ref_o(sel_ref_o), .switch_req_o(switch_req_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic [1:0] e_mode;
  logic [FW-1:0] e_freq, e_avg;
  logic [IW-1:0] e_sel;
  logic e_req;
  int e_cnt;
  string tag;

  task automatic chk(input string t, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic int lowest(input logic [NREF-1:0] m);
    for (int i = NREF - 1; i >= 0; i--) if (m[i]) lowest = i;
    if (m == '0) lowest = -1;
  endfunction

  task automatic model_reset();
    e_mode = 2'b00; e_freq = FW'(NOM); e_avg = FW'(NOM);
    e_sel = '0; e_req = 1'b0; e_cnt = 0;
  endtask

  task automatic model_step();
    logic [FW-1:0] fw;
    logic [NREF-1:0] oth;
    int d;
    fw = FW'(NOM) + cal_offset;
    e_req = 1'b0;
    case (e_mode)
      2'b00: begin
        tag = (ref_valid != 0) ? "R4" : "R3";
        e_freq = fw;
        if (ref_valid != 0) begin
          e_mode = 2'b01; e_sel = IW'(lowest(ref_valid)); e_req = 1'b1;
        end
      end
      2'b01: begin
        if (sel_fail) begin
          if (e_cnt >= FULL) begin
            tag = "R6"; e_mode = 2'b10; e_freq = e_avg;
          end else begin
            tag = "R7"; e_mode = 2'b00; e_freq = fw; e_cnt = 0;
          end
        end else begin
          tag = "R5";
          e_freq = loop_freq;
          d = int'(loop_freq) - int'(e_avg);
          e_avg = FW'(int'(e_avg) + (d >>> K));
          if (e_cnt < FULL) e_cnt++;
        end
      end
      default: begin
        e_freq = e_avg;
        oth = ref_valid;
        oth[e_sel] = 1'b0;
        if (oth != 0) begin
          tag = "R8"; e_mode = 2'b01; e_sel = IW'(lowest(oth)); e_req = 1'b1;
        end else tag = "R9";
      end
    endcase
  endtask

  task automatic compare(input string t);
    chk(t, "mode", int'(mode_o), int'(e_mode));
    chk(t, "freq", int'(freq_o), int'(e_freq));
    chk(t, "sel", int'(sel_ref_o), int'(e_sel));
    chk("R10", "switch_req", int'(switch_req_o), int'(e_req));
    chk("R2", "mode_legal", int'(mode_o != 2'b11), 1);
  endtask

  task automatic tick(input logic [NREF-1:0] v, input logic f,
                      input logic [FW-1:0] lf, input logic [FW-1:0] cal);
    ref_valid = v; sel_fail = f; loop_freq = lf; cal_offset = cal;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; ref_valid = '0; sel_fail = 1'b0; loop_freq = '0; cal_offset = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;

    // R3: free-run with several offsets, including negative ones
    tick(4'b0000, 1'b0, 16'h1234, 16'h0010);
    tick(4'b0000, 1'b1, 16'h1234, 16'hFFF0);
    tick(4'b0000, 1'b0, 16'h0000, 16'h7FFF);
    tick(4'b0000, 1'b0, 16'h0000, 16'h0000);

    // R4: lowest valid index chosen
    tick(4'b0110, 1'b0, 16'h9000, 16'h0005);
    chk("R4", "sel_lowest", int'(sel_ref_o), 1);

    // R7: fail one sample short of the training count
    for (int i = 0; i < FULL - 1; i++) tick(4'b0110, 1'b0, 16'h9000 + 16'(i*64), 16'h0005);
    tick(4'b0110, 1'b1, 16'hAAAA, 16'h0005);
    chk("R7", "mode_free", int'(mode_o), 0);

    // relock, exactly FULL samples, then fail -> holdover (R6)
    tick(4'b1000, 1'b0, 16'h0000, 16'h0003);
    for (int i = 0; i < FULL; i++) tick(4'b1000, 1'b0, 16'hC000 - 16'(i*100), 16'h0003);
    tick(4'b0000, 1'b1, 16'h0001, 16'h0003);
    chk("R6", "mode_hold", int'(mode_o), 2);

    // R9: only the failed reference is flagged; sel_fail ignored
    for (int i = 0; i < 6; i++) tick(4'b1000, i[0], 16'h1111, 16'h0000);
    chk("R9", "still_hold", int'(mode_o), 2);

    // R8: hitless switch to another reference
    tick(4'b1010, 1'b0, 16'h2222, 16'h0000);
    chk("R8", "new_sel", int'(sel_ref_o), 1);
    tick(4'b1010, 1'b0, 16'h2222, 16'h0000);

    // near-exhaustive pseudo-random sweep
    lfsr = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      logic [NREF-1:0] v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = (lfsr[3:0] < 4'd3) ? 4'b0000 : lfsr[7:4];
      if (n % 9 != 0) v = ref_valid;
      tick(v, (lfsr[11:9] == 3'b000), {lfsr[7:0], lfsr[15:8]}, {{12{lfsr[2]}}, lfsr[5:2]});
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule